// File: doc/BRIEF.md
# Page Access Permission and Protection-Key Checker

This block makes the final allow-or-deny decision for one memory access once a page-table walk has produced the leaf attributes. It takes the user, writable and no-execute attributes already merged across all levels of the walk, the leaf dirty bit and the page's protection key. It also takes the kind and privilege of the access and the paging control bits. It returns the read/write/execute rights that a translation cache may record for the page, a pass flag for the current access and the page-fault error code that an exception would report.

The block is purely combinational and settles in a single cycle. Two outcomes of the walk come in as inputs: a missing entry (not present) and a reserved-bit violation. Both take priority over the permission rules. Protection keys are looked up in one of two rights words, chosen by whether the page is a user page or a supervisor page. Each enabled word removes rights on top of the ordinary page permissions.

Top module: `pkc_access_check`

## Requirements
- R1: Error code bits: bit 0 protection, bit 1 write, bit 2 user, bit 3 reserved-bit, bit 4 fetch, bit 5 key. When `walk_absent` is 1, the access fails with `grant` = 0 and bit 0 clear. Bits 1, 2 and 4 are set as R10 describes.
- R2: When `walk_rsvd` is 1 and `walk_absent` is 0, the access fails with bits 3 and 0 set, and bits 1, 2 and 4 as applicable.
- R3: A user access (`acc_user` = 1) to a page with `pg_user` = 0 fails with bit 0 set and bits 5 and 3 clear, whatever the key rights are.
- R4: Read is granted unless `sup_guard` = 1, `acc_user` = 0 and `pg_user` = 1. The guard has no effect on user accesses.
- R5: Write is granted only together with read, and only when `pg_write` = 1 or when the access is supervisor with `ctl_wp` = 0.
- R6: Execute is granted when `pg_nx` = 0, unless the access is supervisor, `ctl_xprev` = 1 and `pg_user` = 1.
- R7: For key k, user pages use `ukey_rights` only when `ctl_ukey_en` = 1, and supervisor pages use `skey_rights` only when `ctl_skey_en` = 1. A disabled or unselected word has no effect.
- R8: Bit 2k of the selected word removes read and write. Bit 2k+1 removes write, but only for user accesses or when `ctl_wp` = 1. Execute is never removed by a key.
- R9: When the selected key rights forbid the access type, the code has bits 5 and 0 set. This takes priority over an ordinary permission denial.
- R10: On any fault, bit 1 equals (`acc_type` = 1) and bit 2 equals `acc_user`. Bit 4 is set only when `acc_type` = 2 and (`ctl_nxe` or `ctl_xprev`) is 1.
- R11: On a successful access with `leaf_dirty` = 0 and `acc_type` other than 1, the write bit is cleared from `grant`.
- R12: `acc_type` is encoded 0 = read, 1 = write, 2 = fetch, and 3 is treated as a read. `grant` is {exec, write, read}. `pass` is the `grant` bit selected by the access type. When `pass` = 1, the code is 0; on a fault, `grant` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pg_user | input | 1 | Merged user attribute of the page |
| pg_write | input | 1 | Merged writable attribute |
| pg_nx | input | 1 | Merged no-execute attribute |
| leaf_dirty | input | 1 | Dirty bit of the leaf entry |
| pg_key | input | KEY_W | Protection key of the page |
| walk_absent | input | 1 | Walk hit a not-present entry |
| walk_rsvd | input | 1 | Walk hit a reserved-bit violation |
| acc_type | input | 2 | 0 read, 1 write, 2 fetch, 3 read |
| acc_user | input | 1 | Access made at user privilege |
| sup_guard | input | 1 | Supervisor data access under user-page prevention |
| ctl_wp | input | 1 | Supervisor write-protect enable |
| ctl_xprev | input | 1 | Supervisor execution-prevention enable |
| ctl_nxe | input | 1 | No-execute enable |
| ctl_ukey_en | input | 1 | User-page key enable |
| ctl_skey_en | input | 1 | Supervisor-page key enable |
| ukey_rights | input | 2*2**KEY_W | Rights word for user pages |
| skey_rights | input | 2*2**KEY_W | Rights word for supervisor pages |
| grant | output | 3 | Granted rights {exec, write, read} |
| pass | output | 1 | Current access allowed |
| fault_code | output | 6 | Page-fault error code |

## Verification
Some properties hold for every input combination, so the assertions check them whenever the inputs change. These are: `pass` excludes a nonzero code, a not-present fault never sets bit 0, a reserved-bit fault carries bit 0, a key fault always carries bit 0, the fetch bit appears only for fetches under an enable, a granted write implies a granted read, and disabled keys leave all rights. The bench covers the remaining ground against its own model. This includes which rights word is chosen for which page kind, the write-disable dependence on privilege and write-protect, the order of precedence among the fault causes, and the clearing of write on clean pages. It uses seeded random vectors together with directed corner cases.

// File: rtl/pkc_pkg.sv
package pkc_pkg;

   typedef enum logic [1:0] {
      ACC_READ  = 2'd0,
      ACC_WRITE = 2'd1,
      ACC_FETCH = 2'd2,
      ACC_ALT   = 2'd3
   } acc_e;

   localparam int PERM_W = 3;
   localparam int PR     = 0;
   localparam int PWR    = 1;
   localparam int PX     = 2;

   localparam int FC_W   = 6;
   localparam int FC_P   = 0;
   localparam int FC_WR  = 1;
   localparam int FC_U   = 2;
   localparam int FC_RS  = 3;
   localparam int FC_I   = 4;
   localparam int FC_PK  = 5;

   typedef logic [PERM_W-1:0] perm_t;
   typedef logic [FC_W-1:0]   fcode_t;

   function automatic logic [1:0] perm_index(input logic [1:0] acc);
      case (acc)
         ACC_WRITE: perm_index = 2'd1;
         ACC_FETCH: perm_index = 2'd2;
         default:   perm_index = 2'd0;
      endcase
   endfunction

endpackage

// File: rtl/pkc_base_perm.sv
module pkc_base_perm
   import pkc_pkg::*;
(
   input  logic  pg_user,
   input  logic  pg_write,
   input  logic  pg_nx,
   input  logic  acc_user,
   input  logic  sup_guard,
   input  logic  ctl_wp,
   input  logic  ctl_xprev,
   output perm_t base
);

   logic guard_hit;
   logic rd_ok;
   logic wr_ok;
   logic ex_ok;

   always_comb begin
      guard_hit = sup_guard & ~acc_user & pg_user;
      rd_ok     = ~guard_hit;
      wr_ok     = rd_ok & (pg_write | ~(acc_user | ctl_wp));
      ex_ok     = ~pg_nx & (acc_user | ~(ctl_xprev & pg_user));
      base      = '0;
      base[PR]  = rd_ok;
      base[PWR] = wr_ok;
      base[PX]  = ex_ok;
   end

   // R5
   always_comb begin
      wr_implies_rd_chk: assert final (!base[PWR] || base[PR])
         else $error("write granted without read");
   end

endmodule

// File: rtl/pkc_key_rights.sv
module pkc_key_rights
   import pkc_pkg::*;
#(
   parameter int KEY_W = 4
) (
   input  logic                        pg_user,
   input  logic [KEY_W-1:0]            pg_key,
   input  logic                        acc_user,
   input  logic                        ctl_wp,
   input  logic                        ctl_ukey_en,
   input  logic                        ctl_skey_en,
   input  logic [2*(1<<KEY_W)-1:0]     ukey_rights,
   input  logic [2*(1<<KEY_W)-1:0]     skey_rights,
   output perm_t                       key_mask
);

   localparam int NKEYS = 1 << KEY_W;

   logic [NKEYS-1:0] u_deny;
   logic [NKEYS-1:0] u_nowr;
   logic [NKEYS-1:0] s_deny;
   logic [NKEYS-1:0] s_nowr;

   for (genvar g = 0; g < NKEYS; g++) begin : g_split
      assign u_deny[g] = ukey_rights[2*g];
      assign u_nowr[g] = ukey_rights[2*g+1];
      assign s_deny[g] = skey_rights[2*g];
      assign s_nowr[g] = skey_rights[2*g+1];
   end

   logic deny_all;
   logic deny_wr;
   logic wr_rule;

   always_comb begin
      if (pg_user) begin
         deny_all = ctl_ukey_en & u_deny[pg_key];
         deny_wr  = ctl_ukey_en & u_nowr[pg_key];
      end else begin
         deny_all = ctl_skey_en & s_deny[pg_key];
         deny_wr  = ctl_skey_en & s_nowr[pg_key];
      end
      wr_rule       = deny_wr & (acc_user | ctl_wp);
      key_mask      = '1;
      key_mask[PR]  = ~deny_all;
      key_mask[PWR] = ~deny_all & ~wr_rule;
   end

   // R7
   always_comb begin
      keys_off_chk: assert final ((ctl_ukey_en || ctl_skey_en) || key_mask == '1)
         else $error("key mask active with keys disabled");
   end

   // R8
   always_comb begin
      key_no_exec_chk: assert final (key_mask[PX])
         else $error("key removed execute");
   end

endmodule

// File: rtl/pkc_fault_code.sv
module pkc_fault_code
   import pkc_pkg::*;
(
   input  logic       walk_absent,
   input  logic       walk_rsvd,
   input  logic       user_viol,
   input  logic       key_viol,
   input  logic       prot_viol,
   input  logic [1:0] acc_type,
   input  logic       acc_user,
   input  logic       ctl_nxe,
   input  logic       ctl_xprev,
   output logic       any_fault,
   output fcode_t     code
);

   logic later;

   always_comb begin
      later     = walk_rsvd | user_viol | key_viol | prot_viol;
      any_fault = walk_absent | later;
      code      = '0;
      if (any_fault) begin
         code[FC_P]  = ~walk_absent & later;
         code[FC_RS] = ~walk_absent & walk_rsvd;
         code[FC_PK] = ~walk_absent & ~walk_rsvd & ~user_viol & key_viol;
         code[FC_WR] = (acc_type == ACC_WRITE);
         code[FC_U]  = acc_user;
         code[FC_I]  = (acc_type == ACC_FETCH) & (ctl_nxe | ctl_xprev);
      end
   end

endmodule

// File: rtl/pkc_access_check.sv
module pkc_access_check
   import pkc_pkg::*;
#(
   parameter int KEY_W = 4
) (
   input  logic                    pg_user,
   input  logic                    pg_write,
   input  logic                    pg_nx,
   input  logic                    leaf_dirty,
   input  logic [KEY_W-1:0]        pg_key,
   input  logic                    walk_absent,
   input  logic                    walk_rsvd,
   input  logic [1:0]              acc_type,
   input  logic                    acc_user,
   input  logic                    sup_guard,
   input  logic                    ctl_wp,
   input  logic                    ctl_xprev,
   input  logic                    ctl_nxe,
   input  logic                    ctl_ukey_en,
   input  logic                    ctl_skey_en,
   input  logic [2*(1<<KEY_W)-1:0] ukey_rights,
   input  logic [2*(1<<KEY_W)-1:0] skey_rights,
   output logic [2:0]              grant,
   output logic                    pass,
   output logic [5:0]              fault_code
);

   localparam int NKEYS = 1 << KEY_W;

   initial begin
      key_w_range_chk: assert (KEY_W >= 1 && KEY_W <= 6)
         else $error("KEY_W out of range");
      rights_width_chk: assert (2*NKEYS <= 128)
         else $error("rights word too wide");
   end

   perm_t  base;
   perm_t  key_mask;
   perm_t  merged;
   fcode_t code;
   logic   any_fault;
   logic   user_viol;
   logic   key_viol;
   logic   prot_viol;
   logic [1:0] sel;

   pkc_base_perm u_base (
      .pg_user   (pg_user),
      .pg_write  (pg_write),
      .pg_nx     (pg_nx),
      .acc_user  (acc_user),
      .sup_guard (sup_guard),
      .ctl_wp    (ctl_wp),
      .ctl_xprev (ctl_xprev),
      .base      (base)
   );

   pkc_key_rights #(.KEY_W(KEY_W)) u_keys (
      .pg_user     (pg_user),
      .pg_key      (pg_key),
      .acc_user    (acc_user),
      .ctl_wp      (ctl_wp),
      .ctl_ukey_en (ctl_ukey_en),
      .ctl_skey_en (ctl_skey_en),
      .ukey_rights (ukey_rights),
      .skey_rights (skey_rights),
      .key_mask    (key_mask)
   );

   always_comb begin
      sel       = perm_index(acc_type);
      merged    = base & key_mask;
      user_viol = acc_user & ~pg_user;
      key_viol  = ~key_mask[sel];
      prot_viol = ~merged[sel];
   end

   pkc_fault_code u_code (
      .walk_absent (walk_absent),
      .walk_rsvd   (walk_rsvd),
      .user_viol   (user_viol),
      .key_viol    (key_viol),
      .prot_viol   (prot_viol),
      .acc_type    (acc_type),
      .acc_user    (acc_user),
      .ctl_nxe     (ctl_nxe),
      .ctl_xprev   (ctl_xprev),
      .any_fault   (any_fault),
      .code        (code)
   );

   always_comb begin
      grant = '0;
      if (!any_fault) begin
         grant      = merged;
         grant[PWR] = merged[PWR] & (leaf_dirty | (acc_type == ACC_WRITE));
      end
      pass       = grant[sel];
      fault_code = code;
   end

   // R12
   always_comb begin
      pass_code_chk: assert final (!pass || fault_code == '0)
         else $error("pass with nonzero code");
   end

   // R1
   always_comb begin
      absent_chk: assert final (!walk_absent || (!fault_code[FC_P] && !pass && grant == '0))
         else $error("absent fault wrong");
   end

   // R2
   always_comb begin
      rsvd_chk: assert final (walk_absent || !walk_rsvd || (fault_code[FC_RS] && fault_code[FC_P]))
         else $error("reserved fault wrong");
   end

   // R9
   always_comb begin
      key_pair_chk: assert final (!fault_code[FC_PK] || fault_code[FC_P])
         else $error("key bit without protection bit");
   end

   // R10
   always_comb begin
      fetch_bit_chk: assert final (!fault_code[FC_I] || (acc_type == ACC_FETCH && (ctl_nxe || ctl_xprev)))
         else $error("fetch bit misplaced");
   end

   // R11
   always_comb begin
      clean_chk: assert final (!(pass && !leaf_dirty && acc_type != ACC_WRITE) || !grant[PWR])
         else $error("write left on clean page");
   end

endmodule

// File: tb/sim_pkc_access_check.sv
module sim_pkc_access_check;

   localparam int KW = 4;
   localparam int RW = 2*(1<<KW);

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic          pg_user, pg_write, pg_nx, leaf_dirty;
   logic [KW-1:0] pg_key;
   logic          walk_absent, walk_rsvd;
   logic [1:0]    acc_type;
   logic          acc_user, sup_guard, ctl_wp, ctl_xprev, ctl_nxe;
   logic          ctl_ukey_en, ctl_skey_en;
   logic [RW-1:0] ukey_rights, skey_rights;
   logic [2:0]    grant;
   logic          pass;
   logic [5:0]    fault_code;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 0;

   pkc_access_check #(.KEY_W(KW)) u0 (.*);

   function automatic logic [9:0] model();
      bit [5:0] c;
      bit [2:0] g;
      bit wr, fe, ok, rd_p, wr_p, ex_p, ad, wd;
      int idx;
      c   = '0;
      g   = '0;
      wr  = (acc_type == 2'd1);
      fe  = (acc_type == 2'd2);
      idx = wr ? 1 : (fe ? 2 : 0);
      ok  = 0;
      if (walk_absent) begin
         c = '0;
      end else if (walk_rsvd) begin
         c[3] = 1; c[0] = 1;
      end else if (acc_user && !pg_user) begin
         c[0] = 1;
      end else begin
         rd_p = !(sup_guard && !acc_user && pg_user);
         wr_p = rd_p && (pg_write || (!acc_user && !ctl_wp));
         ex_p = !pg_nx && (acc_user || !(ctl_xprev && pg_user));
         if (pg_user) begin
            ad = ctl_ukey_en && ukey_rights[2*pg_key];
            wd = ctl_ukey_en && ukey_rights[2*pg_key+1];
         end else begin
            ad = ctl_skey_en && skey_rights[2*pg_key];
            wd = ctl_skey_en && skey_rights[2*pg_key+1];
         end
         if (ad) begin rd_p = 0; wr_p = 0; end
         if ((idx == 0 && ad) || (idx == 1 && (ad || (wd && (acc_user || ctl_wp))))) begin
            c[5] = 1; c[0] = 1;
         end else begin
            if (wd && (acc_user || ctl_wp)) wr_p = 0;
            g = {ex_p, wr_p, rd_p};
            if (g[idx]) ok = 1;
            else c[0] = 1;
         end
      end
      if (ok) begin
         if (!leaf_dirty && !wr) g[1] = 0;
         return {1'b1, g, 6'd0};
      end
      c[1] = wr;
      c[2] = acc_user;
      c[4] = fe && (ctl_nxe || ctl_xprev);
      return {1'b0, 3'd0, c};
   endfunction

   task automatic chk(input string tag);
      logic [9:0] e;
      @(negedge clk);
      #1;
      e = model();
      n_chk++;
      if (pass !== e[9] || grant !== e[8:6] || fault_code !== e[5:0]) begin
         n_fail++;
         $display("FAIL %s: got pass=%b grant=%b code=%b, expected pass=%b grant=%b code=%b",
                  tag, pass, grant, fault_code, e[9], e[8:6], e[5:0]);
      end
   endtask

   task automatic expect_code(input string tag, input logic [5:0] exp_c, input logic exp_p);
      n_chk++;
      if (fault_code !== exp_c || pass !== exp_p) begin
         n_fail++;
         $display("FAIL %s: got code=%b pass=%b, expected code=%b pass=%b",
                  tag, fault_code, pass, exp_c, exp_p);
      end
   endtask

   task automatic clear_all();
      pg_user = 0; pg_write = 0; pg_nx = 0; leaf_dirty = 0; pg_key = '0;
      walk_absent = 0; walk_rsvd = 0; acc_type = 2'd0; acc_user = 0;
      sup_guard = 0; ctl_wp = 0; ctl_xprev = 0; ctl_nxe = 0;
      ctl_ukey_en = 0; ctl_skey_en = 0; ukey_rights = '0; skey_rights = '0;
   endtask

   initial begin
      #(8*200000);
      if (!done) begin
         n_fail++;
         n_chk++;
         $display("FAIL watchdog: got timeout, expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h1234_5eed));
      clear_all();
      chk("R12 idle inputs");

      // R1: absent, user write
      walk_absent = 1; acc_user = 1; acc_type = 2'd1; pg_user = 1; pg_write = 1;
      chk("R1 absent user write");
      expect_code("R1 absent code", 6'b000110, 0);
      // R10: fetch with nxe
      acc_type = 2'd2; ctl_nxe = 1; acc_user = 0;
      chk("R10 absent fetch nxe");
      expect_code("R10 fetch bit", 6'b010000, 0);
      ctl_nxe = 0;
      chk("R10 fetch without enables");
      expect_code("R10 no fetch bit", 6'b000000, 0);

      // R2
      clear_all(); walk_rsvd = 1; acc_type = 2'd1;
      chk("R2 reserved write");
      expect_code("R2 code", 6'b001011, 0);

      // R3: user access to supervisor page with keys that would deny
      clear_all(); acc_user = 1; pg_write = 1; ctl_skey_en = 1; skey_rights = '1;
      chk("R3 user to sup page");
      expect_code("R3 code", 6'b000101, 0);

      // R4: guard on user page
      clear_all(); pg_user = 1; pg_write = 1; leaf_dirty = 1; sup_guard = 1;
      chk("R4 guard blocks read");
      acc_user = 1;
      chk("R4 guard ignored for user");
      expect_code("R4 user read passes", 6'b000000, 1);

      // R5: supervisor write to read-only, wp on/off
      clear_all(); acc_type = 2'd1; leaf_dirty = 1;
      chk("R5 sup write wp off");
      expect_code("R5 sup write passes", 6'b000000, 1);
      ctl_wp = 1;
      chk("R5 sup write wp on");
      expect_code("R5 denied", 6'b000011, 0);

      // R6: exec rules
      clear_all(); acc_type = 2'd2; pg_user = 1; ctl_xprev = 1;
      chk("R6 xprev sup on user page");
      expect_code("R6 code", 6'b010001, 0);
      acc_user = 1;
      chk("R6 user fetch ok");
      pg_nx = 1;
      chk("R6 nx blocks");

      // R7/R8/R9: keys
      clear_all(); pg_user = 1; pg_write = 1; leaf_dirty = 1; acc_user = 1; pg_key = 4'd5;
      ukey_rights = '0; ukey_rights[10] = 1;
      chk("R7 user key disabled");
      ctl_ukey_en = 1;
      chk("R8 access disable read");
      expect_code("R9 key code", 6'b100101, 0);
      skey_rights = '1; ctl_skey_en = 1; ukey_rights = '0;
      chk("R7 sup word unused on user page");
      expect_code("R7 passes", 6'b000000, 1);
      ukey_rights[11] = 1; acc_type = 2'd1;
      chk("R8 write disable user");
      expect_code("R9 wd code", 6'b100111, 0);
      acc_type = 2'd2;
      chk("R8 key keeps exec");
      // supervisor write-disable depends on wp
      clear_all(); pg_write = 1; leaf_dirty = 1; acc_type = 2'd1; pg_key = 4'd15;
      ctl_skey_en = 1; skey_rights[31] = 1;
      chk("R8 sup wd wp off");
      expect_code("R8 sup wd ignored", 6'b000000, 1);
      ctl_wp = 1;
      chk("R9 sup wd wp on");

      // R11: clean page
      clear_all(); pg_write = 1; acc_type = 2'd0;
      chk("R11 clean read drops write");
      acc_type = 2'd3;
      chk("R12 code 3 as read");
      acc_type = 2'd1;
      chk("R11 clean write keeps write");

      for (int i = 0; i < 4000; i++) begin
         pg_user     = 1'($urandom);
         pg_write    = 1'($urandom);
         pg_nx       = 1'($urandom);
         leaf_dirty  = 1'($urandom);
         pg_key      = KW'($urandom);
         walk_absent = ($urandom % 16) == 0;
         walk_rsvd   = ($urandom % 16) == 0;
         acc_type    = 2'($urandom);
         acc_user    = 1'($urandom);
         sup_guard   = 1'($urandom);
         ctl_wp      = 1'($urandom);
         ctl_xprev   = 1'($urandom);
         ctl_nxe     = 1'($urandom);
         ctl_ukey_en = 1'($urandom);
         ctl_skey_en = 1'($urandom);
         ukey_rights = $urandom & $urandom;
         skey_rights = $urandom & $urandom;
         chk("R12 random");
      end

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule